// File: doc/BRIEF.md
# Keyed-Disable Watchdog Timer

This block is a 16-bit down-counting watchdog reached through a small register interface. It has three registers: a control word, a shared load/count word, and a mode word. Software enables the watchdog through the mode word. It selects a prescale code and the auto-reload behaviour in the control word. It services the watchdog by writing a fresh count to the load/count word. While the watchdog is enabled and started, the count falls by one on every prescaled tick. When the count runs out, the block pulses an interrupt and raises a reset request. The reset request stays high until the system reset.

Software cannot turn the watchdog off with a single write. It must write an arm key and then, as the very next bus write, a confirm key to the mode word. Any other write in between cancels the attempt. Software can also force an expiry on purpose: with the watchdog enabled, it writes zero to the load/count word twice in a row.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the watchdog is disabled and not armed. The count and the reload value are 0xFFFF, the control word is 0, and both `irq_o` and `rst_req_o` are low.
- R2: Offset 0x0 is the control word. It keeps only bit 7 (start), bit 8 (auto-reload) and bits 11:9 (prescale code), and its other bits read as zero. A write to offset 0x2 sets both the reload value and the count, and a read of 0x2 returns the live count. A read of offset 0x4 returns the enable flag in bit 15 and the armed flag in bit 0. Other offsets read as zero.
- R3: When the key is not armed, a write to offset 0x4 with bit 15 set enables the watchdog.
- R4: The count falls by one on each tick, but only while the watchdog is enabled and the start bit is set. A tick comes once every 2^code clock cycles, where code is the prescale code. The prescaler restarts on a load write, and also whenever counting is stopped. While counting is stopped, the count holds its value.
- R5: When a tick takes the count from 1 to 0, `irq_o` is high for the next cycle and `rst_req_o` is set. If auto-reload is clear, the count then stays at 0 and no further expiry follows.
- R6: If auto-reload is set, the expiring tick loads the count from the last value written to offset 0x2.
- R7: `rst_req_o` stays high until reset, even after the watchdog is disabled.
- R8: Writing 0x00F5 to offset 0x4 arms the key. If the next bus write is 0x00A0 to offset 0x4, the watchdog is disabled and the count then holds.
- R9: After the key is armed, any other bus write disarms it: a write to another offset, or a mode write of any value other than 0x00A0, including 0x00F5 again. The watchdog stays enabled, and a later 0x00A0 on its own has no effect.
- R10: With the watchdog enabled, two consecutive bus writes of 0x0000 to offset 0x2 raise `irq_o` and `rst_req_o` in the next cycle. Cycles without a write do not break the pair, but any other bus write does. While the watchdog is disabled, the pair does nothing.
- R11: If a load write and a tick fall in the same cycle, the load write wins: the count takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Write strobe for one cycle |
| bus_addr_i | input | 3 | Byte offset of the register |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i (combinational) |
| irq_o | output | 1 | One-cycle expiry interrupt |
| rst_req_o | output | 1 | Sticky reset request |

## Verification
A write that lands on a clock edge shows up on the read port straight after that edge. The count reacts to a tick at the edge where the tick is sampled. `irq_o` and `rst_req_o` rise in the cycle that follows the edge at which the last decrement, or the second zero write, is taken. The bench drives each stimulus just after a falling edge. It compares the read data and both outputs against its own model 1 ns later. It then advances the model on the next rising edge with the same inputs, so every result is checked in the exact cycle it falls due.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int DATA_W      = 16;
    localparam int ADDR_W      = 3;
    localparam int PRE_CODE_W  = 3;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_LOAD = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_MODE = 3'd4;

    localparam int CTRL_START_BIT = 7;
    localparam int CTRL_AUTO_BIT  = 8;
    localparam int CTRL_PRE_LSB   = 9;

    localparam logic [DATA_W-1:0] KEY_ARM     = 16'h00F5;
    localparam logic [DATA_W-1:0] KEY_CONFIRM = 16'h00A0;

    typedef enum logic {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } key_state_e;

    typedef struct packed {
        logic       en;
        key_state_e st;
    } key_regs_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              restart_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              tick_o
);
    localparam int PRE_W = (1 << CODE_W) - 1;

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] lim;

    always_comb begin
        lim    = PRE_W'((32'd1 << code_i) - 32'd1);
        tick_o = run_i && (pre_q >= lim);
        pre_d  = pre_q;
        if (restart_i || !run_i) begin
            pre_d = '0;
        end else if (tick_o) begin
            pre_d = '0;
        end else begin
            pre_d = pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> !tick_o) else $error("tick while stopped"); // R4
endmodule

// File: rtl/wdt_keylock.sv
module wdt_keylock
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              mode_sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              enabled_o,
    output logic              armed_o
);
    key_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_i) begin
            if (mode_sel_i) begin
                if (r_q.st == KEY_ARMED) begin
                    r_d.st = KEY_IDLE;
                    if (wdata_i == KEY_CONFIRM) r_d.en = 1'b0;
                    else if (wdata_i[DATA_W-1]) r_d.en = 1'b1;
                end else if (wdata_i == KEY_ARM) begin
                    r_d.st = KEY_ARMED;
                end else if (wdata_i[DATA_W-1]) begin
                    r_d.en = 1'b1;
                end
            end else begin
                r_d.st = KEY_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{en: 1'b0, st: KEY_IDLE};
        else        r_q <= r_d;
    end

    assign enabled_o = r_q.en;
    assign armed_o   = (r_q.st == KEY_ARMED);

    AST_ENABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && mode_sel_i && !armed_o && wdata_i[DATA_W-1]) |=> enabled_o)
        else $error("enable write ignored"); // R3
    AST_CONFIRM_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && mode_sel_i && armed_o && wdata_i == KEY_CONFIRM) |=> !enabled_o)
        else $error("confirm did not disable"); // R8
    AST_FALL_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(enabled_o) |-> $past(armed_o))
        else $error("disabled without key"); // R8
    AST_CANCEL_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && armed_o && enabled_o && !(mode_sel_i && wdata_i == KEY_CONFIRM))
        |=> (enabled_o && !armed_o))
        else $error("cancel misbehaved"); // R9
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_any_i,
    input  logic              load_wr_i,
    input  logic [DATA_W-1:0] load_val_i,
    input  logic              tick_i,
    input  logic              auto_i,
    input  logic              en_i,
    output logic [DATA_W-1:0] count_o,
    output logic              irq_o,
    output logic              rst_req_o
);
    typedef struct packed {
        logic [DATA_W-1:0] count;
        logic [DATA_W-1:0] reload;
        logic              last_zero;
        logic              irq;
        logic              rst_req;
    } cnt_regs_t;

    cnt_regs_t c_d, c_q;

    always_comb begin
        c_d     = c_q;
        c_d.irq = 1'b0;
        if (load_wr_i) begin
            c_d.count     = load_val_i;
            c_d.reload    = load_val_i;
            c_d.last_zero = (load_val_i == '0);
            if (en_i && c_q.last_zero && load_val_i == '0) begin
                c_d.irq     = 1'b1;
                c_d.rst_req = 1'b1;
            end
        end else begin
            if (wr_any_i) c_d.last_zero = 1'b0;
            if (tick_i && c_q.count != '0) begin
                if (c_q.count == DATA_W'(1)) begin
                    c_d.irq     = 1'b1;
                    c_d.rst_req = 1'b1;
                    c_d.count   = auto_i ? c_q.reload : '0;
                end else begin
                    c_d.count = c_q.count - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{count: '1, reload: '1, last_zero: 1'b0, irq: 1'b0, rst_req: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign count_o   = c_q.count;
    assign irq_o     = c_q.irq;
    assign rst_req_o = c_q.rst_req;

    AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> rst_req_o) else $error("reset request dropped"); // R7
    AST_IRQ_WITH_RST: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> rst_req_o) else $error("irq without reset request"); // R5
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_wr_i && !tick_i) |=> $stable(count_o)) else $error("count moved"); // R4
    AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_wr_i && tick_i && count_o > DATA_W'(1)) |=> count_o == $past(count_o) - 1'b1)
        else $error("bad decrement"); // R4
    AST_EXPIRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_wr_i && tick_i && count_o == DATA_W'(1) && !auto_i) |=> (count_o == '0 && irq_o))
        else $error("expiry without hold"); // R5
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr_i |=> count_o == $past(load_val_i)) else $error("load lost"); // R11
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o,
    output logic              rst_req_o
);
    localparam logic [DATA_W-1:0] CTRL_MASK =
        DATA_W'((((1 << PRE_CODE_W) - 1) << CTRL_PRE_LSB)
                | (1 << CTRL_AUTO_BIT) | (1 << CTRL_START_BIT));

    logic [DATA_W-1:0]     ctrl_d, ctrl_q;
    logic                  sel_ctrl, sel_load, sel_mode;
    logic                  load_wr, enabled, armed, run, tick;
    logic [PRE_CODE_W-1:0] pre_code;
    logic [DATA_W-1:0]     count;

    always_comb begin
        sel_ctrl = (bus_addr_i == OFS_CTRL);
        sel_load = (bus_addr_i == OFS_LOAD);
        sel_mode = (bus_addr_i == OFS_MODE);
        load_wr  = bus_wr_i && sel_load;
        ctrl_d   = ctrl_q;
        if (bus_wr_i && sel_ctrl) ctrl_d = bus_wdata_i & CTRL_MASK;
        pre_code = ctrl_q[CTRL_PRE_LSB +: PRE_CODE_W];
        run      = enabled && ctrl_q[CTRL_START_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    wdt_keylock u_key (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (bus_wr_i),
        .mode_sel_i (sel_mode),
        .wdata_i    (bus_wdata_i),
        .enabled_o  (enabled),
        .armed_o    (armed)
    );

    wdt_prescaler #(.CODE_W(PRE_CODE_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .restart_i (load_wr),
        .code_i    (pre_code),
        .tick_o    (tick)
    );

    wdt_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_any_i   (bus_wr_i),
        .load_wr_i  (load_wr),
        .load_val_i (bus_wdata_i),
        .tick_i     (tick),
        .auto_i     (ctrl_q[CTRL_AUTO_BIT]),
        .en_i       (enabled),
        .count_o    (count),
        .irq_o      (irq_o),
        .rst_req_o  (rst_req_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (sel_ctrl) begin
            bus_rdata_o = ctrl_q;
        end else if (sel_load) begin
            bus_rdata_o = count;
        end else if (sel_mode) begin
            bus_rdata_o[DATA_W-1] = enabled;
            bus_rdata_o[0]        = armed;
        end
    end

    AST_CTRL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~CTRL_MASK) == '0) else $error("control stray bits"); // R2
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load_wr) |=> $stable(count)) else $error("count moved while stopped"); // R4
endmodule

// File: tb/keyed_watchdog_tb_top.sv
module keyed_watchdog_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        irq, rst_req;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";
    bit done = 0;

    // behavioural reference state
    logic [15:0] m_count, m_load, m_ctrl;
    bit          m_en, m_armed, m_lastzero, m_irq, m_rst;
    int          m_pre;

    always #4 clk = ~clk;

    keyed_watchdog dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .rst_req_o(rst_req)
    );

    task automatic m_reset();
        m_count = 16'hFFFF; m_load = 16'hFFFF; m_ctrl = 16'h0;
        m_en = 0; m_armed = 0; m_lastzero = 0; m_irq = 0; m_rst = 0; m_pre = 0;
    endtask

    function automatic logic [15:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_ctrl;
            3'd2: return m_count;
            3'd4: return {m_en, 14'h0, m_armed};
            default: return 16'h0;
        endcase
    endfunction

    task automatic m_clock(input bit w, input logic [2:0] a, input logic [15:0] d);
        bit running, tick;
        int lim;
        running = m_en && m_ctrl[7];
        lim = (1 << m_ctrl[11:9]) - 1;
        tick = running && (m_pre >= lim);
        m_irq = 0;
        if (w && a == 3'd2) begin
            if (m_en && m_lastzero && d == 16'h0) begin m_irq = 1; m_rst = 1; end
            m_count = d; m_load = d; m_lastzero = (d == 16'h0); m_pre = 0;
        end else begin
            if (w) m_lastzero = 0;
            if (!running) m_pre = 0;
            else if (tick) m_pre = 0;
            else m_pre = m_pre + 1;
            if (tick && m_count != 0) begin
                if (m_count == 1) begin
                    m_irq = 1; m_rst = 1;
                    m_count = m_ctrl[8] ? m_load : 16'h0;
                end else m_count = m_count - 1;
            end
        end
        if (w && a == 3'd0) m_ctrl = d & 16'h0F80;
        if (w && a == 3'd4) begin
            if (m_armed) begin
                m_armed = 0;
                if (d == 16'h00A0) m_en = 0;
                else if (d[15]) m_en = 1;
            end else if (d == 16'h00F5) m_armed = 1;
            else if (d[15]) m_en = 1;
        end else if (w) m_armed = 0;
    endtask

    task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic step(input bit w, input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr = w; addr = a; wdata = d;
        #1;
        chk("rdata", rdata, m_read(a));
        chk("irq", {15'h0, irq}, {15'h0, m_irq});
        chk("rst_req", {15'h0, rst_req}, {15'h0, m_rst});
        @(posedge clk);
        m_clock(w, a, d);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
        step(1, a, d);
    endtask

    task automatic idle(input logic [2:0] a, input int n);
        for (int i = 0; i < n; i++) step(0, a, 16'h0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; wr = 0;
        m_reset();
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        m_reset();
        do_reset();
        cur_req = "R1";
        idle(3'd0, 1); idle(3'd2, 1); idle(3'd4, 1);
        cur_req = "R2";
        idle(3'd6, 1);
        wr_reg(3'd0, 16'hFFFF); idle(3'd0, 1);
        wr_reg(3'd0, 16'h0000); wr_reg(3'd2, 16'h1234); idle(3'd2, 1); idle(3'd6, 1);
        cur_req = "R3";
        wr_reg(3'd4, 16'h8000); idle(3'd4, 1); idle(3'd2, 3);
        cur_req = "R4";
        wr_reg(3'd0, 16'h0080); idle(3'd2, 6);
        wr_reg(3'd0, 16'h0480); wr_reg(3'd2, 16'h0008); idle(3'd2, 12);
        cur_req = "R5";
        idle(3'd2, 30);
        cur_req = "R7";
        wr_reg(3'd4, 16'h00F5); wr_reg(3'd4, 16'h00A0); idle(3'd4, 3); idle(3'd2, 3);

        do_reset();
        cur_req = "R6";
        wr_reg(3'd4, 16'h8000); wr_reg(3'd2, 16'h0003); wr_reg(3'd0, 16'h0180); idle(3'd2, 20);
        cur_req = "R11";
        for (int i = 0; i < 6; i++) wr_reg(3'd2, 16'h0002);
        idle(3'd2, 5);

        do_reset();
        cur_req = "R8";
        wr_reg(3'd4, 16'h8000); wr_reg(3'd2, 16'h0100); wr_reg(3'd0, 16'h0080); idle(3'd2, 3);
        wr_reg(3'd4, 16'h00F5); idle(3'd4, 1); wr_reg(3'd4, 16'h00A0);
        idle(3'd2, 5); idle(3'd4, 2);
        cur_req = "R9";
        wr_reg(3'd4, 16'h8000); wr_reg(3'd4, 16'h00F5); wr_reg(3'd4, 16'h0001);
        wr_reg(3'd4, 16'h00A0); idle(3'd4, 2);
        wr_reg(3'd4, 16'h00F5); wr_reg(3'd0, 16'h0080); wr_reg(3'd4, 16'h00A0); idle(3'd4, 1);
        wr_reg(3'd4, 16'h00F5); wr_reg(3'd4, 16'h00F5); wr_reg(3'd4, 16'h00A0);
        idle(3'd4, 1); idle(3'd2, 2);
        cur_req = "R10";
        wr_reg(3'd0, 16'h0000); wr_reg(3'd2, 16'h0000); wr_reg(3'd0, 16'h0000);
        wr_reg(3'd2, 16'h0000); idle(3'd2, 3);
        wr_reg(3'd2, 16'h0000); idle(3'd2, 2); wr_reg(3'd2, 16'h0000); idle(3'd2, 3);

        do_reset();
        cur_req = "R10";
        wr_reg(3'd2, 16'h0000); wr_reg(3'd2, 16'h0000); idle(3'd2, 3);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule